// File: doc/BRIEF.md
# PATA PIO Strobe Timing Generator

This block times programmed-I/O cycles on a parallel ATA bus for two channels with two devices each. Every device (a "unit", numbered `2*channel + device`) owns a 16-bit timing word. Its low byte times read cycles and its high byte times write cycles. In each byte the low nibble sets how long the strobe is asserted and the high nibble sets the recovery gap. Both are stored in complemented form, so a zero byte gives the slowest cycle. A byte-wide configuration port writes and reads these words. The same port also reaches a control byte, which holds one IORDY-bypass bit per unit, and a status byte, which mirrors the busy flags of the per-channel posted-write buffers.

A requester raises `req_valid` with a channel, a device and a direction while `req_ready` is high. The block then drives the read strobe `dior_n` or the write strobe `diow_n` low for the active time and holds it high for the recovery time. It pulses `cyc_done` for one clock and returns to idle. When IORDY is honoured for the unit, a low IORDY at the last active clock stretches the strobe one clock at a time. A write to the control byte while any posted-write buffer is busy is held back and applied once the buffers drain.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset every timing byte reads 0x00, the control byte (0x42) reads 0x00, both strobes are high, `cyc_done` is low and `req_ready` is high.
- R2: The timing byte for unit u is at address 0x44+2u for reads and at 0x45+2u for writes, where u = 2*channel + device. A written value reads back unchanged. Unmapped addresses such as 0x40 and 0x4C read 0x00.
- R3: The strobe goes low on the clock after acceptance. It stays low for 17-L clocks, where L is the low nibble of the unit's byte for that direction, so the width runs from 2 to 17 clocks.
- R4: After the active time the strobe stays high for 16-H clocks, where H is the high nibble of the same byte, so the gap runs from 1 to 16 clocks, before `cyc_done` rises.
- R5: A read cycle pulses only `dior_n` and uses the byte at 0x44+2u. A write cycle pulses only `diow_n` and uses the byte at 0x45+2u. The two strobes are never low together.
- R6: `cyc_done` is high for exactly one clock, directly after recovery. `req_ready` is high only while idle, so the next request is accepted no earlier than the clock after `cyc_done`.
- R7: Bit 4+u of the control byte 0x42 set means unit u ignores IORDY. Clear means that, if IORDY is low at the last active clock, the strobe stays low until IORDY is sampled high. Bits 3:0 of 0x42 always read 0.
- R8: Status byte 0x43 bit c reads the busy flag `wbuf_busy[c]` of channel c (bits 1:0), and its other bits read 0.
- R9: A write to 0x42 while any `wbuf_busy` bit is set leaves the readable control byte unchanged. The held value takes effect on the first clock at which no busy bit is set. A later write made while the first is still held replaces the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| wbuf_busy | input | 2 | Per-channel posted-write buffer busy flags |
| req_valid | input | 1 | PIO cycle request |
| req_chan | input | 1 | Channel of the request |
| req_dev | input | 1 | Device of the request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_ready | output | 1 | Block idle and able to accept a request |
| iordy | input | 1 | Device ready input, already synchronised |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cyc_done | output | 1 | One-clock pulse at the end of a cycle |

## Verification
The bench drives every nibble value into both the read and the write byte of rotating units. It compares the strobes, `cyc_done` and `req_ready` with an expected waveform on every clock, so an off-by-one decode would show up as a strobe or gap one clock too long or too short, and a swapped byte would show up as the wrong width. The bench releases IORDY several clocks after the nominal active end, both with the bypass bit clear and with it set. A design that ignored IORDY would end the strobe early, and one that ignored the bypass bit would stretch it. It posts a control write while a buffer is busy, replaces it, then drains the buffer. A design that applied the write at once or kept the stale value would read back the wrong control byte.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int BYTE_W = 8;
    localparam int TIM_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_ACTIVE  = 2'd1,
        SQ_RECOVER = 2'd2,
        SQ_DONE    = 2'd3
    } sq_state_e;

endpackage

// File: rtl/pio_cfg_bank.sv
module pio_cfg_bank
    import pio_timing_pkg::*;
#(
    parameter int NUM_CHAN      = 2,
    parameter int NUM_UNITS     = 4,
    parameter int ADDR_W        = 8,
    parameter int CTRL_ADDR     = 'h42,
    parameter int STAT_ADDR     = 'h43,
    parameter int TIMING_BASE   = 'h44,
    parameter int CTRL_BIT_BASE = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_wr,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [BYTE_W-1:0]                cfg_wdata,
    output logic [BYTE_W-1:0]                cfg_rdata,
    input  logic [NUM_CHAN-1:0]              wbuf_busy,
    output logic [NUM_UNITS-1:0][TIM_W-1:0]  timing_o,
    output logic [NUM_UNITS-1:0]             no_iordy_o
);

    typedef struct packed {
        logic [NUM_UNITS-1:0][TIM_W-1:0] tim;
        logic [NUM_UNITS-1:0]            ctl;
        logic [NUM_UNITS-1:0]            pend_ctl;
        logic                            pend;
    } bank_t;

    bank_t bank_d, bank_q;

    logic                 ctl_write;
    logic                 any_busy;
    logic [NUM_UNITS-1:0] wr_ctl_bits;

    function automatic logic [ADDR_W-1:0] rd_byte_addr(input int u);
        return ADDR_W'(TIMING_BASE + 2 * u);
    endfunction

    function automatic logic [ADDR_W-1:0] wr_byte_addr(input int u);
        return ADDR_W'(TIMING_BASE + 2 * u + 1);
    endfunction

    assign ctl_write = cfg_wr && (cfg_addr == ADDR_W'(CTRL_ADDR));
    assign any_busy  = |wbuf_busy;

    always_comb begin
        wr_ctl_bits = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            wr_ctl_bits[u] = cfg_wdata[CTRL_BIT_BASE + u];
        end
    end

    // next-state computation
    always_comb begin
        bank_d = bank_q;
        if (ctl_write) begin
            if (any_busy) begin
                bank_d.pend     = 1'b1;
                bank_d.pend_ctl = wr_ctl_bits;
            end else begin
                bank_d.ctl  = wr_ctl_bits;
                bank_d.pend = 1'b0;
            end
        end else if (bank_q.pend && !any_busy) begin
            bank_d.ctl  = bank_q.pend_ctl;
            bank_d.pend = 1'b0;
        end
        if (cfg_wr) begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (cfg_addr == rd_byte_addr(u)) begin
                    bank_d.tim[u][BYTE_W-1:0] = cfg_wdata;
                end
                if (cfg_addr == wr_byte_addr(u)) begin
                    bank_d.tim[u][TIM_W-1:BYTE_W] = cfg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    // read-back multiplexer
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == ADDR_W'(CTRL_ADDR)) begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                cfg_rdata[CTRL_BIT_BASE + u] = bank_q.ctl[u];
            end
        end
        if (cfg_addr == ADDR_W'(STAT_ADDR)) begin
            cfg_rdata[NUM_CHAN-1:0] = wbuf_busy;
        end
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (cfg_addr == rd_byte_addr(u)) begin
                cfg_rdata = bank_q.tim[u][BYTE_W-1:0];
            end
            if (cfg_addr == wr_byte_addr(u)) begin
                cfg_rdata = bank_q.tim[u][TIM_W-1:BYTE_W];
            end
        end
    end

    assign timing_o   = bank_q.tim;
    assign no_iordy_o = bank_q.ctl;

    AST_CTRL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        any_busy |=> $stable(bank_q.ctl)); // R9

    AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.pend && !any_busy && !ctl_write) |=> (bank_q.ctl == $past(bank_q.pend_ctl))); // R9

    AST_NO_PEND_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_busy) |=> !bank_q.pend); // R9

endmodule

// File: rtl/pio_time_decode.sv
module pio_time_decode
    import pio_timing_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int ACT_MAX = 17,
    parameter int REC_MAX = 16
) (
    input  logic [BYTE_W-1:0] tbyte,
    output logic [CNT_W-1:0]  act_clks,
    output logic [CNT_W-1:0]  rec_clks
);

    localparam int NIB_W = BYTE_W / 2;

    logic [NIB_W-1:0] act_code;
    logic [NIB_W-1:0] rec_code;

    assign act_code = tbyte[NIB_W-1:0];
    assign rec_code = tbyte[BYTE_W-1:NIB_W];

    // stored fields are complements of the clock counts
    assign act_clks = CNT_W'(ACT_MAX) - CNT_W'(act_code);
    assign rec_clks = CNT_W'(REC_MAX) - CNT_W'(rec_code);

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_timing_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] act_clks,
    input  logic [CNT_W-1:0] rec_clks,
    input  logic             honour_iordy,
    input  logic             iordy,
    output logic             req_ready,
    output logic             dior_n,
    output logic             diow_n,
    output logic             cyc_done
);

    typedef struct packed {
        sq_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rec;
        logic             wr;
        logic             wait_rdy;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    seq_d.st       = SQ_ACTIVE;
                    seq_d.cnt      = act_clks - CNT_W'(1);
                    seq_d.rec      = rec_clks;
                    seq_d.wr       = req_write;
                    seq_d.wait_rdy = honour_iordy;
                end
            end
            SQ_ACTIVE: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end else if (!(seq_q.wait_rdy && !iordy)) begin
                    seq_d.st  = SQ_RECOVER;
                    seq_d.cnt = seq_q.rec - CNT_W'(1);
                end
            end
            SQ_RECOVER: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end else begin
                    seq_d.st = SQ_DONE;
                end
            end
            SQ_DONE: begin
                seq_d.st = SQ_IDLE;
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == SQ_IDLE);
    assign dior_n    = !((seq_q.st == SQ_ACTIVE) && !seq_q.wr);
    assign diow_n    = !((seq_q.st == SQ_ACTIVE) &&  seq_q.wr);
    assign cyc_done  = (seq_q.st == SQ_DONE);

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dior_n || diow_n)); // R5

    AST_ACCEPT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (dior_n != diow_n)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (!cyc_done && req_ready)); // R6

    AST_RECOVER_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_RECOVER && seq_q.cnt == '0) |=> cyc_done); // R4

    AST_IORDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_ACTIVE && seq_q.cnt == '0 && seq_q.wait_rdy && !iordy)
        |=> (dior_n != diow_n)); // R7

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
    import pio_timing_pkg::*;
#(
    parameter int NUM_CHAN     = 2,
    parameter int DEV_PER_CHAN = 2,
    parameter int ADDR_W       = 8,
    parameter int CNT_W        = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [BYTE_W-1:0]   cfg_wdata,
    output logic [BYTE_W-1:0]   cfg_rdata,
    input  logic [NUM_CHAN-1:0] wbuf_busy,
    input  logic                req_valid,
    input  logic                req_chan,
    input  logic                req_dev,
    input  logic                req_write,
    output logic                req_ready,
    input  logic                iordy,
    output logic                dior_n,
    output logic                diow_n,
    output logic                cyc_done
);

    localparam int NUM_UNITS = NUM_CHAN * DEV_PER_CHAN;
    localparam int UNIT_W    = $clog2(NUM_UNITS);

    logic [NUM_UNITS-1:0][TIM_W-1:0] timing_all;
    logic [NUM_UNITS-1:0]            no_iordy;
    logic [UNIT_W-1:0]               unit_idx;
    logic [BYTE_W-1:0]               sel_byte;
    logic [CNT_W-1:0]                act_clks;
    logic [CNT_W-1:0]                rec_clks;

    assign unit_idx = UNIT_W'(req_chan) * UNIT_W'(DEV_PER_CHAN) + UNIT_W'(req_dev);
    assign sel_byte = req_write ? timing_all[unit_idx][TIM_W-1:BYTE_W]
                                : timing_all[unit_idx][BYTE_W-1:0];

    pio_cfg_bank #(
        .NUM_CHAN  (NUM_CHAN),
        .NUM_UNITS (NUM_UNITS),
        .ADDR_W    (ADDR_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .wbuf_busy  (wbuf_busy),
        .timing_o   (timing_all),
        .no_iordy_o (no_iordy)
    );

    pio_time_decode #(
        .CNT_W (CNT_W)
    ) u_decode (
        .tbyte    (sel_byte),
        .act_clks (act_clks),
        .rec_clks (rec_clks)
    );

    pio_strobe_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .act_clks     (act_clks),
        .rec_clks     (rec_clks),
        .honour_iordy (!no_iordy[unit_idx]),
        .iordy        (iordy),
        .req_ready    (req_ready),
        .dior_n       (dior_n),
        .diow_n       (diow_n),
        .cyc_done     (cyc_done)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        (!rst_n) |=> (req_ready && dior_n && diow_n && !cyc_done)); // R1

endmodule

// File: tb/pio_strobe_timer_tb.sv
module pio_strobe_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [1:0] wbuf_busy = 2'b00;
    logic       req_valid = 1'b0;
    logic       req_chan = 1'b0;
    logic       req_dev = 1'b0;
    logic       req_write = 1'b0;
    logic       req_ready;
    logic       iordy = 1'b1;
    logic       dior_n;
    logic       diow_n;
    logic       cyc_done;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    // expected {req_ready, cyc_done, dior_n, diow_n} per clock
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    pio_strobe_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wbuf_busy(wbuf_busy),
        .req_valid(req_valid), .req_chan(req_chan), .req_dev(req_dev),
        .req_write(req_write), .req_ready(req_ready), .iordy(iordy),
        .dior_n(dior_n), .diow_n(diow_n), .cyc_done(cyc_done)
    );

    // per-clock comparison against the reference waveform
    always @(negedge clk) begin
        logic [3:0] e;
        string      t;
        if (rst_n && mon_on && !finished) begin
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = 4'b1011;
                t = "R6 idle";
            end
            total++;
            if ({req_ready, cyc_done, dior_n, diow_n} !== e) begin
                bad++;
                $display("FAIL %s: {ready,done,dior_n,diow_n} got=%b exp=%b at t=%0t",
                         t, {req_ready, cyc_done, dior_n, diow_n}, e, $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000 && !finished) begin
            finished = 1'b1;
            bad++;
            $display("FAIL watchdog: got=expired exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        cfg_addr = a;
        @(negedge clk);
        total++;
        if (cfg_rdata !== exp) begin
            bad++;
            $display("FAIL %s: addr %h got=%h exp=%h", tag, a, cfg_rdata, exp);
        end
    endtask

    // rel: 0 = IORDY high, -1 = IORDY low all cycle, >0 = IORDY released in that active clock
    task automatic run_cycle(input int chan, input int dev, input bit wr,
                             input int act, input int rec, input int rel,
                             input bit honour);
        int width;
        @(posedge clk); #1;
        req_valid = 1'b1; req_chan = chan[0]; req_dev = dev[0]; req_write = wr;
        iordy = (rel == 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        width = (honour && rel > act) ? rel : act;
        for (int i = 0; i < width; i++) begin
            exp_q.push_back(wr ? 4'b0010 : 4'b0001);
            tag_q.push_back("R3 R5 R7 active");
        end
        for (int i = 0; i < rec; i++) begin
            exp_q.push_back(4'b0011);
            tag_q.push_back("R4 recovery");
        end
        exp_q.push_back(4'b0111);
        tag_q.push_back("R6 done");
        if (rel > 0) begin
            repeat (rel - 1) @(posedge clk);
            #1 iordy = 1'b1;
        end
        while (exp_q.size() != 0) @(posedge clk);
        #1 iordy = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset state of every byte
        for (int u = 0; u < 4; u++) begin
            cfg_check(8'(8'h44 + 2 * u), 8'h00, "R1 read byte");
            cfg_check(8'(8'h45 + 2 * u), 8'h00, "R1 write byte");
        end
        cfg_check(8'h42, 8'h00, "R1 control");

        // R2: map and read-back
        for (int u = 0; u < 4; u++) begin
            cfg_write(8'(8'h44 + 2 * u), 8'(8'h10 + u));
            cfg_write(8'(8'h45 + 2 * u), 8'(8'hA0 + u));
        end
        for (int u = 0; u < 4; u++) begin
            cfg_check(8'(8'h44 + 2 * u), 8'(8'h10 + u), "R2 read byte");
            cfg_check(8'(8'h45 + 2 * u), 8'(8'hA0 + u), "R2 write byte");
        end
        cfg_check(8'h40, 8'h00, "R2 unmapped low");
        cfg_check(8'h4C, 8'h00, "R2 unmapped high");

        // R3 R4 R5: every nibble value, read and write, rotating units
        for (int n = 0; n < 16; n++) begin
            int u;
            u = n % 4;
            cfg_write(8'(8'h44 + 2 * u), 8'(((15 - n) << 4) | n));
            cfg_write(8'(8'h45 + 2 * u), 8'((n << 4) | (15 - n)));
            run_cycle(u / 2, u % 2, 1'b0, 17 - n, n + 1, 0, 1'b1);
            run_cycle(u / 2, u % 2, 1'b1, 2 + n, 16 - n, 0, 1'b1);
        end

        // R7: IORDY honoured, released late
        cfg_write(8'h46, 8'h0D);
        cfg_write(8'h47, 8'hFE);
        run_cycle(0, 1, 1'b0, 4, 16, 9, 1'b1);
        run_cycle(0, 1, 1'b1, 3, 1, 6, 1'b1);

        // R7: bypass bit for unit 1, IORDY held low
        cfg_write(8'h42, 8'h2F);
        cfg_check(8'h42, 8'h20, "R7 control bits 3:0 read zero");
        run_cycle(0, 1, 1'b0, 4, 16, -1, 1'b0);
        cfg_write(8'h44, 8'h0E);
        run_cycle(0, 0, 1'b0, 3, 16, 5, 1'b1);

        // R8 status mirror
        wbuf_busy = 2'b01;
        cfg_check(8'h43, 8'h01, "R8 status ch0");
        wbuf_busy = 2'b10;
        cfg_check(8'h43, 8'h02, "R8 status ch1");

        // R9 deferred control write
        cfg_write(8'h42, 8'hF0);
        cfg_check(8'h42, 8'h20, "R9 held while busy");
        cfg_write(8'h42, 8'h30);
        cfg_check(8'h42, 8'h20, "R9 still held");
        @(posedge clk); #1 wbuf_busy = 2'b00;
        cfg_check(8'h42, 8'h30, "R9 applied after drain");
        cfg_check(8'h43, 8'h00, "R8 status clear");

        // R7: unit 0 now bypassed, unit 1 bypassed too
        run_cycle(0, 0, 1'b0, 3, 16, -1, 1'b0);

        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule